// File: doc/BRIEF.md
# Criticality-Aware Thread Issue Arbiter

This block chooses which hardware thread of a four-slot multithreaded in-order pipeline may use the single issue port in each cycle. One slot holds a hard real-time thread. The other three hold threads without hard deadlines. For every slot the pipeline presents a ready signal, meaning that an instruction is available and free of hazards, and an enable bit that can switch the slot off. The arbiter returns a one-hot grant in the same cycle, together with a per-slot flag for the non-hard requests that lost to the hard thread.

The hard thread always wins when it is ready, so its issue timing does not depend on what the other threads do. When the hard thread is idle, the non-hard threads share the port one instruction at a time in rotating order. A slot that is not ready is skipped in that same cycle, so one stalled thread never idles the pipeline while another thread could issue.

Top module: `ciss_issue_arbiter`

## Requirements
- R1: Slot 0 is the hard real-time slot and slots 1 to 3 are non-hard. Bit i of every per-slot vector (ready_i, enable_i, grant_o, preempt_o) belongs to slot i.
- R2: Whenever slot 0 is eligible (ready and enabled), grant_o equals 4'b0001 in that same cycle, whatever the other slots present.
- R3: preempt_o equals the set of eligible non-hard slots in a cycle where slot 0 is granted, and is all zeros in any other cycle. Bit 0 is always zero.
- R4: grant_o has at most one bit set, and it is all zeros when no slot is eligible.
- R5: If any slot is eligible, exactly one eligible slot is granted in that cycle. A granted slot is always eligible.
- R6: A slot whose enable_i bit is low is treated as not ready. It is never granted and never flagged as preempted.
- R7: When slot 0 is not eligible, the search over the non-hard slots starts at a rotating pointer and grants the first eligible slot in the order 1, 2, 3, 1. After slot k is granted, the pointer moves to the slot after k (3 wraps to 1). As a result, the same non-hard slot is not granted twice in a row while another non-hard slot is eligible.
- R8: The pointer keeps its value in cycles where slot 0 is granted or nothing is granted.
- R9: While rst_ni is low and after reset, the pointer selects slot 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 4 | Per-slot ready: instruction available, no hazard |
| enable_i | input | 4 | Per-slot enable; when low the slot is ignored |
| grant_o | output | 4 | One-hot issue grant, same cycle as the request |
| preempt_o | output | 4 | Non-hard requests that lost to the hard slot |

## Verification
The checker covers, on every cycle, several properties that hold regardless of the pointer. These are hard-slot precedence, the exact preemption set, one-hot grants, work conservation, masking by enable, and the rule that no non-hard slot issues twice in a row while a rival is waiting. The bench alone checks the exact rotation order. That covers where the search starts after reset, which slot follows which, and the pointer staying frozen across runs of hard-slot cycles. It does this with a pointer model driven through every ready and enable combination, followed by a long pseudo-random sequence.

// File: rtl/ciss_pkg.sv
package ciss_pkg;
  localparam int unsigned HARD_SLOT = 0;

  function automatic int unsigned wrap_next(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/ciss_qualify.sv
module ciss_qualify #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0] ready_i,
  input  logic [NUM_SLOTS-1:0] enable_i,
  output logic                 hard_req_o,
  output logic [NUM_SLOTS-2:0] soft_req_o
);
  logic [NUM_SLOTS-1:0] elig;

  assign elig       = ready_i & enable_i;
  assign hard_req_o = elig[ciss_pkg::HARD_SLOT];
  assign soft_req_o = elig[NUM_SLOTS-1:1];
endmodule

// File: rtl/ciss_rr_pick.sv
module ciss_rr_pick #(
  parameter int unsigned NUM_REQ = 3,
  localparam int unsigned PTR_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               block_i,
  output logic [NUM_REQ-1:0] gnt_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] pick_idx;
  logic             found;

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int off = 0; off < int'(NUM_REQ); off++) begin
      int idx;
      idx = int'(ptr_q) + off;
      if (idx >= int'(NUM_REQ)) idx = idx - int'(NUM_REQ);
      if (!found && req_i[idx]) begin
        found    = 1'b1;
        pick_idx = PTR_W'(idx);
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    ptr_d = ptr_q;
    if (found && !block_i) begin
      gnt_o[pick_idx] = 1'b1;
      ptr_d = PTR_W'(ciss_pkg::wrap_next(int'(pick_idx), NUM_REQ));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end
endmodule

// File: rtl/ciss_issue_arbiter.sv
module ciss_issue_arbiter #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SLOTS-1:0] ready_i,
  input  logic [NUM_SLOTS-1:0] enable_i,
  output logic [NUM_SLOTS-1:0] grant_o,
  output logic [NUM_SLOTS-1:0] preempt_o
);
  localparam int unsigned NUM_SOFT = NUM_SLOTS - 1;

  logic                hard_req;
  logic [NUM_SOFT-1:0] soft_req;
  logic [NUM_SOFT-1:0] soft_gnt;

  ciss_qualify #(.NUM_SLOTS(NUM_SLOTS)) u_qual (
    .ready_i   (ready_i),
    .enable_i  (enable_i),
    .hard_req_o(hard_req),
    .soft_req_o(soft_req)
  );

  // hard slot blocks the soft picker and freezes its pointer
  ciss_rr_pick #(.NUM_REQ(NUM_SOFT)) u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (soft_req),
    .block_i(hard_req),
    .gnt_o  (soft_gnt)
  );

  assign grant_o   = {soft_gnt, hard_req};
  assign preempt_o = hard_req ? {soft_req, 1'b0} : '0;
endmodule

// File: rtl/ciss_issue_arbiter_chk.sv
module ciss_issue_arbiter_chk #(
  parameter int unsigned NUM_SLOTS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_SLOTS-1:0] ready_i,
  input logic [NUM_SLOTS-1:0] enable_i,
  input logic [NUM_SLOTS-1:0] grant_o,
  input logic [NUM_SLOTS-1:0] preempt_o
);
  logic [NUM_SLOTS-1:0] elig;
  logic                 seen_q;

  assign elig = ready_i & enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r2_hard_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elig[0] |-> (grant_o == NUM_SLOTS'(1)));

  a_r3_preempt_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o[0] |-> (preempt_o == (elig & ~NUM_SLOTS'(1))));

  a_r3_preempt_only_hard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preempt_o != '0) |-> grant_o[0]);

  a_r4_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  a_r5_no_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig != '0) |-> (grant_o != '0));

  a_r6_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o | preempt_o) & ~elig) == '0);

  a_r7_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !elig[0] && ($countones(elig[NUM_SLOTS-1:1]) >= 2))
      |-> ((grant_o[NUM_SLOTS-1:1] & $past(grant_o[NUM_SLOTS-1:1])) == '0));
endmodule

bind ciss_issue_arbiter ciss_issue_arbiter_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_i  (ready_i),
  .enable_i (enable_i),
  .grant_o  (grant_o),
  .preempt_o(preempt_o)
);

// File: tb/tb_ciss_issue_arbiter.sv
module tb_ciss_issue_arbiter;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ready = '0;
  logic [3:0] en = '0;
  logic [3:0] grant, preempt;
  int errors = 0;
  int checks = 0;
  int ptr = 0;  // model: 0..2 -> slot 1..3
  bit done = 1'b0;

  ciss_issue_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .ready_i(ready), .enable_i(en),
    .grant_o(grant), .preempt_o(preempt)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_grant(input logic [3:0] r, input logic [3:0] e, input int p);
    logic [3:0] el = r & e;
    if (el[0]) return 4'b0001;
    for (int off = 0; off < 3; off++) begin
      int s = (p + off) % 3;
      if (el[s+1]) return 4'(1 << (s + 1));
    end
    return 4'b0000;
  endfunction

  // drive at negedge, check mid-low phase, model pointer moves at next posedge
  task automatic step(input logic [3:0] r, input logic [3:0] e);
    logic [3:0] eg, ep, el;
    @(negedge clk);
    ready = r; en = e;
    #(PERIOD/4);
    el = r & e;
    eg = ref_grant(r, e, ptr);
    ep = el[0] ? (el & 4'b1110) : 4'b0000;
    if (el[0])         check("R2 hard grant", grant, eg);
    else if (el == 0)  check("R4 idle grant", grant, eg);
    else               check("R7 rotation", grant, eg);
    check("R3 preempt", preempt, ep);
    check("R6 grant within eligible", grant & ~el, 4'b0000);
    if (el != 0) check("R5 work conserving", {3'b0, grant != 0}, 4'b0001);
    if (!el[0] && grant[3:1] != 0)
      for (int s = 1; s < 4; s++) if (eg[s]) ptr = s % 3;
  endtask

  initial begin
    #(PERIOD*150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    ready = 4'b1110; en = 4'b1111;
    repeat (3) @(negedge clk);
    check("R9 reset pointer", grant, 4'b0010);
    check("R3 reset preempt", preempt, 4'b0000);
    rst_n = 1'b1;

    // R1: each slot alone maps to its own grant bit
    for (int s = 0; s < 4; s++) begin
      step(4'(1 << s), 4'b1111);
      check("R1 slot map", grant, 4'(1 << s));
    end

    // R8: pointer frozen across hard-slot cycles and idle cycles
    step(4'b0010, 4'b1111);
    repeat (3) step(4'b1111, 4'b1111);
    repeat (2) step(4'b0000, 4'b1111);
    step(4'b1110, 4'b1111);
    check("R8 pointer held", grant, 4'b0100);

    // R6: disabled hard slot neither wins nor blocks
    step(4'b1111, 4'b1110);
    check("R6 disabled hard", grant[0] ? 4'b1 : 4'b0, 4'b0);

    // exhaustive ready x enable, three passes from differing pointer phases
    for (int pass = 0; pass < 3; pass++)
      for (int i = 0; i < 256; i++) step(4'(i), 4'(i >> 4));

    // long soft-only contention, then pseudo-random traffic
    repeat (30) step(4'b1110, 4'b1111);
    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0], lfsr[7:4] | 4'b1000);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule